// File: doc/BRIEF.md
# Quadrature Position Counter Channel

A single counter channel of configurable width (24 bits by default) that sits on a 16-bit register port. It counts the edges of two encoder phases at one, two or four counts per cycle, or it counts every cycle of the system clock. A 16-bit mode word packs the whole configuration: clock source, how the direction is chosen, how counting is enabled, whether an index edge reloads the count, how readback is latched and what drives the output pin. Two preload registers hold reload values. They are written through the same pair of word addresses, and a select bit in the mode word picks the target.

Software reads the count as a low word and then a high word. The low-word read freezes the full count into a holding register, so the two halves always belong to the same sample. Alternatively, an index edge can freeze the count. A command register accepts strobes to zero the count, to load it from preload register 0, and to clear the capture flag. The capture flag is set when the count wraps or when the index reloads it, and it can drive the output pin.

Word addresses on `bus_addr`: 0 is the count/preload low word, 1 is the count/preload high word, 2 is the mode word and 3 is the command register. Mode word fields: bit 0 is the output source, bit 1 the output polarity, bits 4:2 the reload trigger, bits 6:5 the hardware enable source, bits 8:7 the enable control, bits 10:9 the clock source, bit 11 the software direction, bit 12 the direction control, bit 13 the latch control and bit 14 the preload select. Bit 15 is reserved.

Top module: `qcnt_channel`

## Requirements
- R1: After reset the count, the mode word and the capture flag are zero, so `cnt_out` is 0 and reads of addresses 0, 1 and 2 return 0.
- R2: With clock source 3 (mode bits 10:9), every legal phase change counts once. The phases step through 00, 10, 11, 01 (written as A then B) to count up, and through that sequence in reverse to count down.
- R3: Clock source 0 counts only on rising edges of phase A. Clock source 1 counts on both edges of phase A. In both cases the direction comes from phase B.
- R4: A phase change in which A and B toggle together leaves the count unchanged, and later legal changes count normally.
- R5: Clock source 2 counts once per system clock. With direction control 1 (bit 12), bit 11 sets the direction: 0 counts up and 1 counts down.
- R6: Enable control 0 (bits 8:7) stops counting. Enable control 1 counts freely. Enable control 2 or 3 counts only while the hardware source picked by bits 6:5 is true; source 0 is `gate_in` high, after a two-flop synchronizer.
- R7: A write to address 1 stages the high bits. The following write to address 0 commits the full value to preload register 0 or 1, as chosen by bit 14. Command bit 14 loads the count from preload register 0. Command bit 15 zeroes the count and wins over bit 14.
- R8: The count wraps modulo 2^24 in both directions, and each wrap sets the capture flag.
- R9: With reload trigger 4 (bits 4:2), a rising `enc_idx` loads the count from the preload register chosen by bit 14 and sets the capture flag. With trigger 0, the index edge changes neither.
- R10: Command bit 3 clears the capture flag. `cnt_out` is the capture flag XOR bit 1 when bit 0 is 0, and the count MSB XOR bit 1 when bit 0 is 1.
- R11: With latch control 0 (bit 13), a read of address 0 returns the live low word and freezes the count. The next read of address 1 returns the frozen upper 8 bits, zero-extended, even if the count has moved.
- R12: With latch control 1, a rising index edge freezes the count. Reads of addresses 0 and 1 return the frozen value and not the live count.
- R13: Reading address 2 returns the last mode word written, with bit 15 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next clock |
| bus_addr | input | 2 | Word address (0 low, 1 high, 2 mode, 3 command) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| gate_in | input | 1 | Hardware count gate (asynchronous) |
| cnt_out | output | 1 | Output pin: capture flag or count MSB, with selectable polarity |

## Verification
The bench drives both phases through full cycles in each direction and at each decode rate. A decoder with the wrong edge selection miscounts by a factor of two or four, and one that mixes up the phase order counts the wrong way. It makes A and B change together, which a naive edge counter would count. It steps the count down from zero and up through the top value, where an unsized wrap or a missing flag shows up. It reads the low word and then waits until a carry reaches the upper byte before reading the high word, which catches a design that returns the live high word. It also issues zero and load in the same command, and it pulses the index with reload and latch both on and off.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
   localparam int WORD_W = 16;

   // Packed mode word; bit order matters because software composes it.
   typedef struct packed {
      logic       rsvd;       // 15
      logic       pl_sel;     // 14
      logic       latch_idx;  // 13
      logic       dir_sw;     // 12
      logic       sw_down;    // 11
      logic [1:0] clk_src;    // 10:9
      logic [1:0] en_ctl;     // 8:7
      logic [1:0] hw_src;     // 6:5
      logic [2:0] reload;     // 4:2
      logic       out_pol;    // 1
      logic       out_msb;    // 0
   } mode_t;

   typedef enum logic [1:0] {
      CS_X1  = 2'd0,
      CS_X2  = 2'd1,
      CS_INT = 2'd2,
      CS_X4  = 2'd3
   } clk_src_e;

   typedef enum logic [1:0] {
      RA_LOW  = 2'd0,
      RA_HIGH = 2'd1,
      RA_MODE = 2'd2,
      RA_CMD  = 2'd3
   } reg_addr_e;

   localparam logic [2:0] RELOAD_ON_INDEX = 3'd4;
   localparam int CMD_ZERO_BIT  = 15;
   localparam int CMD_LOAD_BIT  = 14;
   localparam int CMD_CLEAR_BIT = 3;
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "qcnt_sync: STAGES must be at least 2");
      assert (W >= 1) else $fatal(1, "qcnt_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/qcnt_quad.sv
module qcnt_quad
   import qcnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ph_a,
   input  logic       ph_b,
   input  logic [1:0] clk_src,
   output logic       step,
   output logic       up
);
   logic a_q, b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= ph_a;
         b_q <= ph_b;
      end
   end

   logic a_chg, b_chg;
   assign a_chg = ph_a ^ a_q;
   assign b_chg = ph_b ^ b_q;

   // A leading B counts up: new A differs from old B on every forward edge.
   assign up = ph_a ^ b_q;

   always_comb begin
      case (clk_src)
         CS_X1:   step = a_chg & ~b_chg & ph_a;
         CS_X2:   step = a_chg & ~b_chg;
         CS_X4:   step = a_chg ^ b_chg;
         default: step = 1'b1;
      endcase
   end

   // R4: simultaneous phase toggles never produce a count
   a_r4_no_step_on_double_change: assert property (@(posedge clk) disable iff (!rst_n)
      (a_chg && b_chg && clk_src != CS_INT) |-> !step);
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
   import qcnt_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   input  logic        enc_a,
   input  logic        enc_b,
   input  logic        enc_idx,
   input  logic        gate_in,
   output logic        cnt_out
);
   localparam int               HI_W    = CNT_W - WORD_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   initial begin
      assert (CNT_W > WORD_W && CNT_W < 2 * WORD_W)
         else $fatal(1, "qcnt_channel: CNT_W must lie between 17 and 31");
   end

   // ---------------- input synchronization ----------------
   logic [3:0] raw_in, syn;
   assign raw_in = {gate_in, enc_idx, enc_b, enc_a};

   qcnt_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   mode_t mode_q;
   logic  q_step, q_up;

   qcnt_quad i_quad (
      .clk     (clk),
      .rst_n   (rst_n),
      .ph_a    (syn[0]),
      .ph_b    (syn[1]),
      .clk_src (mode_q.clk_src),
      .step    (q_step),
      .up      (q_up)
   );

   logic idx_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= 1'b0;
      else        idx_q <= syn[2];
   end

   // ---------------- register decode ----------------
   logic wr_lo, wr_hi, wr_mode, wr_cmd;
   assign wr_lo   = bus_wr && (bus_addr == RA_LOW);
   assign wr_hi   = bus_wr && (bus_addr == RA_HIGH);
   assign wr_mode = bus_wr && (bus_addr == RA_MODE);
   assign wr_cmd  = bus_wr && (bus_addr == RA_CMD);

   logic cmd_zero, cmd_load, cmd_clear;
   assign cmd_zero  = wr_cmd && bus_wdata[CMD_ZERO_BIT];
   assign cmd_load  = wr_cmd && bus_wdata[CMD_LOAD_BIT];
   assign cmd_clear = wr_cmd && bus_wdata[CMD_CLEAR_BIT];

   // ---------------- state ----------------
   logic [CNT_W-1:0] count, hold, pl0, pl1;
   logic [HI_W-1:0]  hi_stage;
   logic             cap_flag;

   logic idx_rise, idx_reload;
   assign idx_rise   = syn[2] & ~idx_q;
   assign idx_reload = idx_rise && (mode_q.reload == RELOAD_ON_INDEX);

   logic [CNT_W-1:0] reload_val;
   assign reload_val = mode_q.pl_sel ? pl1 : pl0;

   logic hw_en, cnt_en, cnt_up, do_step, wrap;
   always_comb begin
      case (mode_q.hw_src)
         2'd0:    hw_en = syn[3];
         2'd1:    hw_en = ~syn[3];
         2'd2:    hw_en = ~cap_flag;
         default: hw_en = cap_flag;
      endcase
      case (mode_q.en_ctl)
         2'd0:    cnt_en = 1'b0;
         2'd1:    cnt_en = 1'b1;
         default: cnt_en = hw_en;
      endcase
      if (mode_q.dir_sw)                 cnt_up = ~mode_q.sw_down;
      else if (mode_q.clk_src == CS_INT) cnt_up = 1'b1;
      else                               cnt_up = q_up;
   end

   assign do_step = cnt_en & q_step;
   assign wrap    = do_step & (cnt_up ? (count == CNT_MAX) : (count == '0));

   logic [CNT_W-1:0] count_nx;
   logic             flag_set;
   always_comb begin
      if (cmd_zero)        count_nx = '0;
      else if (cmd_load)   count_nx = pl0;
      else if (idx_reload) count_nx = reload_val;
      else if (do_step)    count_nx = cnt_up ? count + CNT_ONE : count - CNT_ONE;
      else                 count_nx = count;
      flag_set = (idx_reload | wrap) & ~cmd_zero & ~cmd_load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         cap_flag <= 1'b0;
         mode_q   <= '0;
         pl0      <= '0;
         pl1      <= '0;
         hi_stage <= '0;
      end else begin
         count <= count_nx;
         if (flag_set)       cap_flag <= 1'b1;
         else if (cmd_clear) cap_flag <= 1'b0;
         if (wr_mode) mode_q <= mode_t'({1'b0, bus_wdata[WORD_W-2:0]});
         if (wr_hi)   hi_stage <= bus_wdata[HI_W-1:0];
         if (wr_lo) begin
            if (mode_q.pl_sel) pl1 <= {hi_stage, bus_wdata};
            else               pl0 <= {hi_stage, bus_wdata};
         end
      end
   end

   // ---------------- readback ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         bus_rdata <= '0;
      end else begin
         if (mode_q.latch_idx && idx_rise) hold <= count;
         if (bus_rd) begin
            case (bus_addr)
               RA_LOW: begin
                  if (mode_q.latch_idx) begin
                     bus_rdata <= hold[WORD_W-1:0];
                  end else begin
                     bus_rdata <= count[WORD_W-1:0];
                     hold      <= count;
                  end
               end
               RA_HIGH: bus_rdata <= {{(WORD_W-HI_W){1'b0}}, hold[CNT_W-1:WORD_W]};
               RA_MODE: bus_rdata <= mode_q;
               default: bus_rdata <= '0;
            endcase
         end
      end
   end

   assign cnt_out = (mode_q.out_msb ? count[CNT_W-1] : cap_flag) ^ mode_q.out_pol;

   // ---------------- assertions ----------------
   // R2: an applied step moves the count by exactly one
   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (do_step && !bus_wr && !idx_reload) |=>
         (count == $past(count) + CNT_ONE) || (count == $past(count) - CNT_ONE));

   // R6: disabled counting keeps the count still
   a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.en_ctl == 2'd0 && !bus_wr && !idx_reload) |=> $stable(count));

   // R7: the zero command always leaves a zero count
   a_r7_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_zero |=> (count == '0));

   // R8: an up step from the top value wraps to zero and raises the flag
   a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (do_step && cnt_up && count == CNT_MAX && !bus_wr && !idx_reload) |=>
         (count == '0 && cap_flag));

   // R10: clearing without a concurrent set event drops the flag
   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clear && !idx_reload && !wrap) |=> !cap_flag);

   // R11: high-word reads carry no bits above the count width
   a_r11_high_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == RA_HIGH) |=> (bus_rdata[WORD_W-1:HI_W] == '0));
endmodule

// File: tb/test_qcnt_channel.sv
`timescale 1ns/1ps
module test_qcnt_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        enc_a = 1'b0;
   logic        enc_b = 1'b0;
   logic        enc_idx = 1'b0;
   logic        gate_in = 1'b0;
   logic        cnt_out;

   always #5 clk = ~clk;

   qcnt_channel i_qcnt_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .enc_idx   (enc_idx),
      .gate_in   (gate_in),
      .cnt_out   (cnt_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        mon_due = 1'b0;

   // Monitor: pops the expectation pushed by the driver and compares.
   always @(posedge clk) mon_due <= bus_rd;
   always @(negedge clk) begin
      if (mon_due && exp_q.size() > 0) begin
         logic [15:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
         end
      end
   end

   function automatic logic [15:0] mw(int clk_src = 0, int en_ctl = 0, int hw_src = 0,
                                      int reload = 0, int sw_down = 0, int dir_sw = 0,
                                      int latch_idx = 0, int pl_sel = 0, int out_pol = 0,
                                      int out_msb = 0);
      logic [15:0] m;
      m        = '0;
      m[0]     = out_msb[0];
      m[1]     = out_pol[0];
      m[4:2]   = reload[2:0];
      m[6:5]   = hw_src[1:0];
      m[8:7]   = en_ctl[1:0];
      m[10:9]  = clk_src[1:0];
      m[11]    = sw_down[0];
      m[12]    = dir_sw[0];
      m[13]    = latch_idx[0];
      m[14]    = pl_sel[0];
      return m;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [15:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pin_chk(input logic e, input string t);
      n_checks++;
      if (cnt_out !== e) begin
         n_fail++;
         $display("FAIL %s: cnt_out got %b expected %b", t, cnt_out, e);
      end
   endtask

   task automatic phase(input logic a, input logic b);
      enc_a = a; enc_b = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic idx_pulse();
      enc_idx = 1'b1;
      repeat (4) @(negedge clk);
      enc_idx = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run got hung expected completion");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      pin_chk(1'b0, "R1 pin after reset");
      rd_chk(2'd0, 16'h0000, "R1 low after reset");
      rd_chk(2'd1, 16'h0000, "R1 high after reset");
      rd_chk(2'd2, 16'h0000, "R1 mode after reset");

      // R2 x4 up four, down three
      wr(2'd2, mw(.clk_src(3), .en_ctl(1)));
      phase(1,0); phase(1,1); phase(0,1); phase(0,0);
      rd_chk(2'd0, 16'h0004, "R2 x4 up");
      rd_chk(2'd1, 16'h0000, "R2 x4 up high");
      phase(0,1); phase(1,1); phase(1,0);
      rd_chk(2'd0, 16'h0001, "R2 x4 down");

      // R4 both phases toggle together
      phase(0,1);
      rd_chk(2'd0, 16'h0001, "R4 double change ignored");
      phase(0,0);
      rd_chk(2'd0, 16'h0002, "R4 legal change after");

      // R3 x1 then x2
      wr(2'd3, 16'h8000);
      wr(2'd2, mw(.clk_src(0), .en_ctl(1)));
      phase(1,0); phase(1,1); phase(0,1); phase(0,0);
      rd_chk(2'd0, 16'h0001, "R3 x1 one per cycle");
      wr(2'd2, mw(.clk_src(1), .en_ctl(1)));
      phase(1,0); phase(1,1); phase(0,1); phase(0,0);
      rd_chk(2'd0, 16'h0003, "R3 x2 two per cycle");

      // R5 internal clock, software down; R8 wrap below zero
      wr(2'd3, 16'h8000);
      wr(2'd2, mw(.clk_src(2), .en_ctl(1), .dir_sw(1), .sw_down(1)));
      repeat (4) @(negedge clk);
      wr(2'd2, mw(.clk_src(2), .en_ctl(0), .dir_sw(1), .sw_down(1)));
      pin_chk(1'b1, "R8 flag on down wrap");
      rd_chk(2'd0, 16'hFFFB, "R5 internal down low");
      rd_chk(2'd1, 16'h00FF, "R5 internal down high");
      repeat (10) @(negedge clk);
      rd_chk(2'd0, 16'hFFFB, "R6 disabled holds");

      // R10 clear and pin polarity / source
      wr(2'd3, 16'h0008);
      pin_chk(1'b0, "R10 flag cleared");
      wr(2'd2, mw(.out_pol(1)));
      pin_chk(1'b1, "R10 inverted flag");
      wr(2'd2, mw(.out_pol(1), .out_msb(1)));
      pin_chk(1'b0, "R10 inverted msb");
      wr(2'd2, mw(.out_msb(1)));
      pin_chk(1'b1, "R10 msb");

      // R6 hardware gate
      wr(2'd3, 16'h8000);
      wr(2'd2, mw(.clk_src(2), .en_ctl(2), .hw_src(0)));
      repeat (6) @(negedge clk);
      rd_chk(2'd0, 16'h0000, "R6 gate low no count");
      gate_in = 1'b1;
      repeat (10) @(negedge clk);
      gate_in = 1'b0;
      repeat (5) @(negedge clk);
      rd_chk(2'd0, 16'h000A, "R6 gate window count");

      // R7 preload steering and commands
      wr(2'd2, mw());
      wr(2'd1, 16'h0012); wr(2'd0, 16'h3456);
      wr(2'd2, mw(.pl_sel(1)));
      wr(2'd1, 16'h00AB); wr(2'd0, 16'hCDEF);
      wr(2'd3, 16'h4000);
      rd_chk(2'd0, 16'h3456, "R7 load from preload 0 low");
      rd_chk(2'd1, 16'h0012, "R7 load from preload 0 high");
      wr(2'd3, 16'hC000);
      rd_chk(2'd0, 16'h0000, "R7 zero beats load low");
      rd_chk(2'd1, 16'h0000, "R7 zero beats load high");

      // R9 index reload from preload 1, then disabled
      wr(2'd2, mw(.reload(4), .pl_sel(1)));
      idx_pulse();
      pin_chk(1'b1, "R9 index reload sets flag");
      rd_chk(2'd0, 16'hCDEF, "R9 index reload low");
      rd_chk(2'd1, 16'h00AB, "R9 index reload high");
      wr(2'd3, 16'h8008);
      wr(2'd2, mw(.reload(0), .pl_sel(1)));
      idx_pulse();
      pin_chk(1'b0, "R9 trigger off no flag");
      rd_chk(2'd0, 16'h0000, "R9 trigger off no reload");

      // R11 low read freezes the high word
      wr(2'd2, mw());
      wr(2'd1, 16'h0000); wr(2'd0, 16'hFFF0);
      wr(2'd3, 16'h4000);
      wr(2'd2, mw(.clk_src(2), .en_ctl(1)));
      rd_chk(2'd0, 16'hFFF0, "R11 live low");
      repeat (40) @(negedge clk);
      rd_chk(2'd1, 16'h0000, "R11 frozen high");
      wr(2'd2, mw());
      rd_chk(2'd0, 16'h001B, "R11 settled low");
      rd_chk(2'd1, 16'h0001, "R11 settled high");

      // R12 index latch
      wr(2'd2, mw(.latch_idx(1)));
      idx_pulse();
      wr(2'd3, 16'h8000);
      rd_chk(2'd0, 16'h001B, "R12 latched low");
      rd_chk(2'd1, 16'h0001, "R12 latched high");
      wr(2'd2, mw());
      rd_chk(2'd0, 16'h0000, "R12 live count zeroed");

      // R13 mode readback
      wr(2'd2, 16'hFFFF);
      rd_chk(2'd2, 16'h7FFF, "R13 reserved bit reads zero");
      wr(2'd2, mw());

      // R8 up wrap through the top value
      wr(2'd3, 16'h8008);
      wr(2'd1, 16'h00FF); wr(2'd0, 16'hFFFE);
      wr(2'd3, 16'h4000);
      pin_chk(1'b0, "R8 flag clear before wrap");
      wr(2'd2, mw(.clk_src(2), .en_ctl(1)));
      repeat (2) @(negedge clk);
      wr(2'd2, mw());
      pin_chk(1'b1, "R8 flag on up wrap");
      rd_chk(2'd0, 16'h0001, "R8 up wrap low");
      rd_chk(2'd1, 16'h0000, "R8 up wrap high");

      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
      $finish;
   end
endmodule